// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations. Every entry records the address-space identifier of the process that owns it, so mappings belonging to different processes live side by side and a context switch needs no invalidation. A lookup presents a virtual page number, the current address-space identifier and the kind of access (read, write or execute). One cycle later the block answers with a hit and the physical frame number, with a plain miss, or with a protection fault when the page is present but the access kind is not allowed.

On a miss the requester walks the page table elsewhere and hands the result to the fill port, which installs it. An entry may be marked wired: it is never evicted to make room for a fill and survives both invalidation commands. Room for a new translation is found by taking the lowest-numbered empty entry, or, when none is empty, by rotating through the non-wired entries. Two invalidation commands exist: one clears every non-wired entry, the other clears only the non-wired entries of a single address space.

The block only caches and checks permissions. Walking the page table, talking to memory and deciding policy are left to its neighbours.

Top module: `asid_xlate_cache`

## Requirements
- R1: After reset no entry is valid, rsp_valid is low, and every lookup misses until a fill installs a translation.
- R2: A lookup hits only an entry that is valid and whose page number and address-space identifier both equal the request; on a hit rsp_pfn carries that entry's frame, otherwise rsp_pfn is zero and, while rsp_valid is low, rsp_hit and rsp_fault are low.
- R3: rsp_valid is high in exactly the cycle after a cycle with lk_req high, and low after a cycle with lk_req low.
- R4: A fill installs its translation so that a later lookup of the same page number and identifier hits with the filled frame.
- R5: A fill whose page number and identifier match a valid entry overwrites that entry, including its frame and permission, so no two entries ever match the same request.
- R6: A fill that matches nothing goes to the lowest-numbered invalid entry; when all entries are valid it replaces the first non-wired entry at or after a rotating pointer (wrapping), and the pointer then moves to the slot after the victim.
- R7: A valid wired entry is never chosen as a replacement victim and stays valid across both invalidation commands.
- R8: The per-identifier invalidation (inv_asid_en with inv_asid) clears every non-wired entry tagged with that identifier and leaves all other entries intact.
- R9: The global invalidation (inv_all) clears every non-wired entry.
- R10: Permission codes are 0 read-only, 1 read-write, 2 execute-only, 3 no access; access codes are 0 read, 1 write, 2 execute, 3 reserved (never permitted). A matching entry that does not permit the access gives rsp_fault high, rsp_hit low and rsp_pfn zero; hit and fault are never high together.
- R11: A lookup sees the contents as they were before any fill or invalidation in the same cycle; a fill and an invalidation in the same cycle apply the invalidation first and the fill after, so the filled entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_req | input | 1 | Lookup request strobe |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the requester |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Lookup answer present (one cycle after lk_req) |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_fault | output | 1 | Translation found but access not permitted |
| rsp_pfn | output | PFN_W | Physical frame number on a hit, else zero |
| fl_en | input | 1 | Install a translation |
| fl_vpn | input | VPN_W | Page number of the translation to install |
| fl_asid | input | ASID_W | Identifier of the translation to install |
| fl_pfn | input | PFN_W | Frame number of the translation to install |
| fl_perm | input | 2 | Permission code: 0 read-only, 1 read-write, 2 execute-only, 3 none |
| fl_wired | input | 1 | Mark the installed entry as exempt from eviction and invalidation |
| inv_all | input | 1 | Clear all non-wired entries |
| inv_asid_en | input | 1 | Clear the non-wired entries of one identifier |
| inv_asid | input | ASID_W | Identifier selected by inv_asid_en |

## Verification
The lookup path can share a cycle with either the fill path or an invalidation, and a fill can share a cycle with an invalidation. The bench provokes each pairing by driving both strobes in one cycle: a lookup of a page being filled in the same cycle must miss and the next lookup must hit, a lookup during a global invalidation must still hit while the following one misses, and a fill issued together with a global invalidation must survive it. Each answer is queued as an expected item when the request is driven and compared when rsp_valid appears.

// File: rtl/xlate_pkg.sv
// Shared encodings for the address-space-tagged translation cache.
// Assumes two-bit access and permission codes as listed in the brief.
package xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PERM_RO   = 2'd0,
        PERM_RW   = 2'd1,
        PERM_XO   = 2'd2,
        PERM_NONE = 2'd3
    } perm_code_e;

    // Decide whether a permission code admits an access kind.
    function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] acc);
        logic ok;
        case (perm)
            PERM_RO: ok = (acc == ACC_READ);
            PERM_RW: ok = (acc == ACC_READ) || (acc == ACC_WRITE);
            PERM_XO: ok = (acc == ACC_EXEC);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlate_cam.sv
// Parallel tag comparator: flags every valid entry whose page number and
// address-space identifier equal the search key. Purely combinational.
// Assumes the caller keeps at most one entry per key (fill overwrites).
module xlate_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
    input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [ASID_W-1:0]  key_asid,
    output logic [ENTRIES-1:0] match_vec
);

    // One comparator per entry, all evaluated at once.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g]
                           && (ent_vpn[g]  == key_vpn)
                           && (ent_asid[g] == key_asid);
    end

endmodule

// File: rtl/xlate_victim.sv
// Replacement chooser. Prefers the lowest-numbered invalid entry; when the
// array is full it walks from a rotating pointer to the first non-wired
// entry. Holds the rotating pointer, which moves past a victim only when
// the caller reports that a rotating choice was consumed.
// Assumes ENTRIES >= 2.
module xlate_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] wired_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   vic_idx,
    output logic               vic_ok,
    output logic               vic_rotating
);

    logic [IDX_W-1:0] rr_ptr;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             rr_found;
    logic [IDX_W-1:0] rr_idx;

    // Find the lowest-numbered empty slot.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // Find the first non-wired slot at or after the rotating pointer.
    always_comb begin
        rr_found = 1'b0;
        rr_idx   = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            int unsigned j;
            j = (int'(rr_ptr) + k) % ENTRIES;
            if (!wired_vec[j]) begin
                rr_found = 1'b1;
                rr_idx   = IDX_W'(j);
            end
        end
    end

    // Pick between the empty slot and the rotating choice.
    always_comb begin
        vic_rotating = !free_found;
        vic_ok       = free_found || rr_found;
        vic_idx      = free_found ? free_idx : rr_idx;
    end

    // Move the rotating pointer to the slot after a consumed victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (advance) begin
            rr_ptr <= (int'(vic_idx) == ENTRIES - 1) ? '0 : vic_idx + 1'b1;
        end
    end

endmodule

// File: rtl/xlate_resp.sv
// Lookup answer stage: selects the matched entry's frame and permission,
// checks the access kind and registers hit, fault and frame.
// Assumes match_vec is one-hot or zero.
module xlate_resp
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [1:0]         lk_acc,
    input  logic [ENTRIES-1:0] match_vec,
    input  logic [PFN_W-1:0]   ent_pfn  [ENTRIES],
    input  logic [1:0]         ent_perm [ENTRIES],
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic [PFN_W-1:0]   rsp_pfn
);

    logic             any_match;
    logic [PFN_W-1:0] sel_pfn;
    logic [1:0]       sel_perm;
    logic             allowed;

    // Merge the fields of the matched entry.
    always_comb begin
        any_match = |match_vec;
        sel_pfn   = '0;
        sel_perm  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                sel_pfn  = sel_pfn  | ent_pfn[i];
                sel_perm = sel_perm | ent_perm[i];
            end
        end
        allowed = perm_allows(sel_perm, lk_acc);
    end

    // Register the answer one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pfn   <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && any_match && allowed;
            rsp_fault <= lk_req && any_match && !allowed;
            rsp_pfn   <= (lk_req && any_match && allowed) ? sel_pfn : '0;
        end
    end

endmodule

// File: rtl/asid_xlate_cache.sv
// Fully associative, address-space-tagged translation cache.
// Holds the entry array, routes lookups to the answer stage, steers fills to
// an existing matching entry or to the replacement choice, and applies the
// two invalidation commands. Invalidation is applied before a same-cycle
// fill; lookups see the array as it was before either.
// Assumes ENTRIES >= 2.
module asid_xlate_cache
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    input  logic              fl_en,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic [1:0]        fl_perm,
    input  logic              fl_wired,
    input  logic              inv_all,
    input  logic              inv_asid_en,
    input  logic [ASID_W-1:0] inv_asid
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_wired;
    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [ASID_W-1:0]  ent_asid [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    logic [1:0]         ent_perm [ENTRIES];

    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] fill_match;
    logic               fill_hit_any;
    logic [IDX_W-1:0]   fill_hit_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_ok;
    logic               vic_rotating;
    logic               fill_go;
    logic [IDX_W-1:0]   fill_tgt;
    logic               rr_advance;

    xlate_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) u_look_cam (
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_asid  (ent_asid),
        .key_vpn   (lk_vpn),
        .key_asid  (lk_asid),
        .match_vec (look_match)
    );

    xlate_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) u_fill_cam (
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_asid  (ent_asid),
        .key_vpn   (fl_vpn),
        .key_asid  (fl_asid),
        .match_vec (fill_match)
    );

    xlate_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_vec    (ent_valid),
        .wired_vec    (ent_wired),
        .advance      (rr_advance),
        .vic_idx      (vic_idx),
        .vic_ok       (vic_ok),
        .vic_rotating (vic_rotating)
    );

    xlate_resp #(
        .ENTRIES (ENTRIES),
        .PFN_W   (PFN_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_req    (lk_req),
        .lk_acc    (lk_acc),
        .match_vec (look_match),
        .ent_pfn   (ent_pfn),
        .ent_perm  (ent_perm),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_fault (rsp_fault),
        .rsp_pfn   (rsp_pfn)
    );

    // Encode the index of an entry already holding the fill's key.
    always_comb begin
        fill_hit_any = |fill_match;
        fill_hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) begin
                fill_hit_idx = IDX_W'(i);
            end
        end
    end

    // Steer the fill: overwrite a matching entry, else use the victim.
    always_comb begin
        fill_tgt   = fill_hit_any ? fill_hit_idx : vic_idx;
        fill_go    = fl_en && (fill_hit_any || vic_ok);
        rr_advance = fl_en && !fill_hit_any && vic_ok && vic_rotating;
    end

    // Apply invalidations, then the fill, to the entry array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_wired <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_vpn[i]  <= '0;
                ent_asid[i] <= '0;
                ent_pfn[i]  <= '0;
                ent_perm[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!ent_wired[i]) begin
                    if (inv_all) begin
                        ent_valid[i] <= 1'b0;
                    end else if (inv_asid_en && (ent_asid[i] == inv_asid)) begin
                        ent_valid[i] <= 1'b0;
                    end
                end
            end
            if (fill_go) begin
                ent_valid[fill_tgt] <= 1'b1;
                ent_wired[fill_tgt] <= fl_wired;
                ent_vpn[fill_tgt]   <= fl_vpn;
                ent_asid[fill_tgt]  <= fl_asid;
                ent_pfn[fill_tgt]   <= fl_pfn;
                ent_perm[fill_tgt]  <= fl_perm;
            end
        end
    end

endmodule

// File: rtl/xlate_cache_chk.sv
// Property checker for asid_xlate_cache, attached by the bind below.
// Observes the answer ports and the valid and wired vectors of the array.
module xlate_cache_chk #(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic               fl_en,
    input logic               inv_all,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic [PFN_W-1:0]   rsp_pfn,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] wired_vec
);

    // R3: a request is answered in the next cycle.
    p_rsp_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R3: no answer without a request.
    p_no_spurious_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    // R10: hit and fault are exclusive.
    p_hit_fault_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_fault));

    // R2: outputs stay quiet without an answer.
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_fault));

    // R2: frame is zero unless the answer is a hit.
    p_pfn_zero_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0));

    // R7: a valid wired entry never loses its valid bit.
    p_wired_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_vec & wired_vec) != '0) |=>
            (($past(valid_vec & wired_vec) & ~valid_vec) == '0));

    // R9: a global invalidation without a fill leaves only wired entries.
    p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fl_en) |=> ((valid_vec & ~wired_vec) == '0));

endmodule

bind asid_xlate_cache xlate_cache_chk #(
    .ENTRIES (ENTRIES),
    .PFN_W   (PFN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .fl_en     (fl_en),
    .inv_all   (inv_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_pfn   (rsp_pfn),
    .valid_vec (ent_valid),
    .wired_vec (ent_wired)
);

// File: tb/tb_asid_xlate_cache.sv
`timescale 1ns/1ps
// Scoreboard bench: lookup tasks queue the expected answer, a monitor pops
// and compares each answer at the falling edge after it appears.
module tb_asid_xlate_cache;
    import xlate_pkg::*;

    localparam int VPN_W  = 20;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_req = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [1:0]        lk_acc = '0;
    logic              rsp_valid, rsp_hit, rsp_fault;
    logic [PFN_W-1:0]  rsp_pfn;
    logic              fl_en = 1'b0;
    logic [VPN_W-1:0]  fl_vpn = '0;
    logic [ASID_W-1:0] fl_asid = '0;
    logic [PFN_W-1:0]  fl_pfn = '0;
    logic [1:0]        fl_perm = '0;
    logic              fl_wired = 1'b0;
    logic              inv_all = 1'b0;
    logic              inv_asid_en = 1'b0;
    logic [ASID_W-1:0] inv_asid = '0;

    int checks = 0;
    int fails  = 0;
    logic [PFN_W+1:0] exp_q[$];
    string            tag_q[$];
    logic [PFN_W+1:0] cur_e;
    string            cur_t;

    always #2.5 clk = ~clk;

    asid_xlate_cache dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn),
        .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_pfn(fl_pfn),
        .fl_perm(fl_perm), .fl_wired(fl_wired),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic [1:0] acc,
                        input logic eh, input logic ef, input logic [PFN_W-1:0] ep, input string tag);
        lk_req  = 1'b1;
        lk_vpn  = v;
        lk_asid = a;
        lk_acc  = acc;
        exp_q.push_back({eh, ef, ep});
        tag_q.push_back(tag);
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic [PFN_W-1:0] p,
                        input logic [1:0] perm, input logic w);
        fl_en    = 1'b1;
        fl_vpn   = v;
        fl_asid  = a;
        fl_pfn   = p;
        fl_perm  = perm;
        fl_wired = w;
    endtask

    task automatic step();
        @(negedge clk);
        lk_req      = 1'b0;
        fl_en       = 1'b0;
        inv_all     = 1'b0;
        inv_asid_en = 1'b0;
    endtask

    // Monitor: compare each answer with the front of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3", "unexpected answer", 32'd1, 32'd0);
            end else begin
                cur_e = exp_q.pop_front();
                cur_t = tag_q.pop_front();
                chk(cur_t, "hit",   32'(rsp_hit),   32'(cur_e[PFN_W+1]));
                chk(cur_t, "fault", 32'(rsp_fault), 32'(cur_e[PFN_W]));
                chk(cur_t, "pfn",   32'(rsp_pfn),   32'(cur_e[PFN_W-1:0]));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1", "valid after reset", 32'(rsp_valid), 32'd0);

        // R1: empty array misses
        look(20'h5, 8'd1, ACC_READ, 0, 0, 0, "R1 empty miss"); step();

        // R4 / R10: read-write entry
        fill(20'h5, 8'd1, 20'h100, PERM_RW, 0); step();
        chk("R3", "idle after fill", 32'(rsp_valid), 32'd0);
        look(20'h5, 8'd1, ACC_READ,  1, 0, 20'h100, "R4 fill then read"); step();
        look(20'h5, 8'd1, ACC_WRITE, 1, 0, 20'h100, "R10 write on rw");   step();
        look(20'h5, 8'd1, ACC_EXEC,  0, 1, 0,       "R10 exec on rw");    step();

        // R2: key mismatches
        look(20'h5, 8'd2, ACC_READ, 0, 0, 0, "R2 asid mismatch"); step();
        look(20'h6, 8'd1, ACC_READ, 0, 0, 0, "R2 vpn mismatch");  step();

        // R2 / R10: same page, second identifier, read-only
        fill(20'h5, 8'd2, 20'h200, PERM_RO, 0); step();
        look(20'h5, 8'd2, ACC_READ,  1, 0, 20'h200, "R2 second asid");   step();
        look(20'h5, 8'd2, ACC_WRITE, 0, 1, 0,       "R10 write on ro");  step();
        look(20'h5, 8'd1, ACC_READ,  1, 0, 20'h100, "R2 coexisting");    step();

        // R11: lookup and fill of the same key in one cycle
        look(20'h7, 8'd1, ACC_READ, 0, 0, 0, "R11 lookup before fill");
        fill(20'h7, 8'd1, 20'h700, PERM_RW, 0); step();
        look(20'h7, 8'd1, ACC_READ, 1, 0, 20'h700, "R4 after same-cycle fill"); step();

        // R5: refill of an existing key overwrites it
        fill(20'h5, 8'd1, 20'h111, PERM_XO, 0); step();
        look(20'h5, 8'd1, ACC_EXEC, 1, 0, 20'h111, "R5 overwrite exec"); step();
        look(20'h5, 8'd1, ACC_READ, 0, 1, 0,       "R5 overwrite read"); step();

        // R8: per-identifier invalidation
        inv_asid_en = 1'b1; inv_asid = 8'd2; step();
        look(20'h5, 8'd2, ACC_READ, 0, 0, 0,       "R8 asid cleared"); step();
        look(20'h5, 8'd1, ACC_EXEC, 1, 0, 20'h111, "R8 other kept");   step();

        // R7: wired entry survives both invalidations
        fill(20'h9, 8'd3, 20'h300, PERM_RW, 1); step();
        inv_asid_en = 1'b1; inv_asid = 8'd3; step();
        look(20'h9, 8'd3, ACC_READ, 1, 0, 20'h300, "R7 wired vs asid flush"); step();
        inv_all = 1'b1; step();
        look(20'h9, 8'd3, ACC_READ, 1, 0, 20'h300, "R7 wired vs global flush"); step();
        look(20'h5, 8'd1, ACC_EXEC, 0, 0, 0, "R9 global cleared a"); step();
        look(20'h7, 8'd1, ACC_READ, 0, 0, 0, "R9 global cleared b"); step();

        // R6: fill all free slots (slot 1 holds the wired entry)
        for (int k = 0; k < 15; k++) begin
            fill(VPN_W'(32'h40 + k), 8'd4, PFN_W'(32'h1000 + k), PERM_RW, 0);
            step();
        end
        // Full: rotation starts at slot 0, then skips wired slot 1
        fill(20'h50, 8'd4, 20'h2000, PERM_RW, 0); step();
        fill(20'h51, 8'd4, 20'h2001, PERM_RW, 0); step();
        look(20'h40, 8'd4, ACC_READ, 0, 0, 0,        "R6 slot0 replaced");  step();
        look(20'h41, 8'd4, ACC_READ, 0, 0, 0,        "R6 slot2 replaced");  step();
        look(20'h42, 8'd4, ACC_READ, 1, 0, 20'h1002, "R6 slot3 kept");      step();
        look(20'h50, 8'd4, ACC_READ, 1, 0, 20'h2000, "R6 new a");           step();
        look(20'h51, 8'd4, ACC_READ, 1, 0, 20'h2001, "R6 new b");           step();
        look(20'h9,  8'd3, ACC_READ, 1, 0, 20'h300,  "R7 wired not victim"); step();
        fill(20'h52, 8'd4, 20'h2002, PERM_RW, 0); step();
        look(20'h42, 8'd4, ACC_READ, 0, 0, 0,        "R6 pointer advanced"); step();
        look(20'h43, 8'd4, ACC_READ, 1, 0, 20'h1003, "R6 next kept");        step();

        // R11: lookup during a global invalidation sees old contents
        look(20'h43, 8'd4, ACC_READ, 1, 0, 20'h1003, "R11 lookup before flush");
        inv_all = 1'b1; step();
        look(20'h43, 8'd4, ACC_READ, 0, 0, 0, "R9 flushed"); step();

        // R11: fill and global invalidation together, fill survives
        fill(20'h60, 8'd4, 20'h600, PERM_RW, 0);
        inv_all = 1'b1; step();
        look(20'h60, 8'd4, ACC_READ, 1, 0, 20'h600, "R11 fill after flush"); step();

        // R10: no-access code and reserved access kind
        fill(20'h70, 8'd4, 20'h700, PERM_NONE, 0); step();
        look(20'h70, 8'd4, ACC_READ, 0, 1, 0, "R10 none read"); step();
        look(20'h70, 8'd4, ACC_EXEC, 0, 1, 0, "R10 none exec"); step();
        look(20'h60, 8'd4, ACC_RSVD, 0, 1, 0, "R10 reserved access"); step();

        step(); step(); step();
        chk("R3", "answers outstanding", 32'(exp_q.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule